// File: doc/BRIEF.md
# Arrival Window Classifier Counters

This block watches a stream of inbound fronthaul message notifications and sorts each message into one of three timing bins: early, on time or late. Each notification carries the message's arrival timestamp and a reference timestamp, both in nanoseconds. The block adds a programmable minimum and maximum delay to the reference to form a receive window. It then compares the arrival time against that window and bumps the matching 64-bit performance counter.

User-plane messages share one set of three bins. Control-plane messages keep their own three bins for each of 16 port identifiers and for each direction, and each direction has its own pair of delay bounds. A total counter sees every message, whether or not window checking is enabled. A small write port loads the bounds and a control word. A registered read port returns any counter as two 32-bit halves, and the high half is taken from a shadow so that the two reads form a consistent pair.

Top module: `arrival_window_counters`

## Requirements
- R1: After a synchronous reset every counter reads zero, window checking is disabled and all six delay bounds are zero.
- R2: The window spans from reference + minimum delay to reference + maximum delay, with both ends inclusive. An arrival below the start is early, an arrival above the end is late, and any other arrival is on time. If the minimum exceeds the maximum, the early test is applied first.
- R3: A user-plane message (msg_ctrl = 0) uses the user bounds and increments counter 1 (early), 2 (on time) or 3 (late), whatever its direction and port.
- R4: Counter 0 increments once for every cycle in which msg_valid is high.
- R5: A control-plane message (msg_ctrl = 1) uses the uplink bounds when msg_dl = 0 and the downlink bounds when msg_dl = 1. It increments counter 4 + 3*(msg_dl*16 + msg_port) + bin, where the bin is 0 for early, 1 for on time and 2 for late.
- R6: While the enable bit is 0, a message increments only counter 0.
- R7: Configuration addresses are: 0 user min, 1 user max, 2 uplink control min, 3 uplink control max, 4 downlink control min, 5 downlink control max, and 6 control word. In the control word, bit 0 is the enable and bit 1 is the clear. Read word 2k returns the low half of counter k and word 2k+1 returns the high half. Data appears one cycle after rd_en. Any word at or above twice the counter count reads 0.
- R8: A write to the control word with bit 1 set clears every counter at that edge, and the clear wins over an increment in the same cycle. With bit 1 clear, the write leaves all counters unchanged.
- R9: A counter that has reached all ones stays there instead of wrapping.
- R10: Reading a low half captures the high half of the same counter into a shadow. Any high-half read returns that shadow, even if the counter has changed since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address |
| cfg_wdata | input | DLY_W | Configuration write data |
| msg_valid | input | 1 | One message notification this cycle |
| msg_ctrl | input | 1 | 1 = control plane, 0 = user plane |
| msg_dl | input | 1 | 1 = downlink, 0 = uplink |
| msg_port | input | PORT_W | Port identifier |
| msg_arrival | input | TS_W | Arrival time, ns |
| msg_ref | input | TS_W | Reference time, ns |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | RD_AW | Read word address |
| rd_data | output | CNT_W/2 | Read data, one cycle after rd_en |

## Verification
The hardest conditions to reach are saturation and a torn read, because a 64-bit counter never fills within a practical run. The bench therefore adds a second instance with 8-bit counters. On that instance it reads a low half at 15, crosses into the high half with one more message, and checks that the following high read still returns the shadowed 0. It then pumps the counter past 255. The other boundary cases are driven directly: arrivals one nanosecond either side of each window edge, and a clear issued in the same cycle as a message.

// File: rtl/awc_pkg.sv
package awc_pkg;

    typedef enum logic [1:0] {
        BIN_EARLY  = 2'd0,
        BIN_ONTIME = 2'd1,
        BIN_LATE   = 2'd2
    } bin_e;

    typedef enum logic [2:0] {
        CFG_U_MIN  = 3'd0,
        CFG_U_MAX  = 3'd1,
        CFG_UL_MIN = 3'd2,
        CFG_UL_MAX = 3'd3,
        CFG_DL_MIN = 3'd4,
        CFG_DL_MAX = 3'd5,
        CFG_CTRL   = 3'd6
    } cfg_addr_e;

    localparam int DLY_BITS  = 32;
    localparam int IDX_TOTAL = 0;
    localparam int IDX_USER  = 1;
    localparam int IDX_CTRL  = 4;
    localparam int NUM_BINS  = 3;

    typedef struct packed {
        logic [DLY_BITS-1:0] dmin;
        logic [DLY_BITS-1:0] dmax;
    } window_t;

    function automatic int ctrl_index(input int dl, input int port, input int bin, input int nport);
        return IDX_CTRL + NUM_BINS * (dl * nport + port) + bin;
    endfunction

endpackage

// File: rtl/awc_classify.sv
module awc_classify
    import awc_pkg::*;
#(
    parameter int TS_W = 64
) (
    input  logic [TS_W-1:0] arrival,
    input  logic [TS_W-1:0] ref_ts,
    input  window_t         win,
    output bin_e            bin
);
    localparam int PAD = TS_W + 1 - DLY_BITS;

    logic [TS_W:0] open_t, close_t, arr_x;

    always_comb begin
        arr_x   = {1'b0, arrival};
        open_t  = {1'b0, ref_ts} + {{PAD{1'b0}}, win.dmin};
        close_t = {1'b0, ref_ts} + {{PAD{1'b0}}, win.dmax};
        if (arr_x < open_t)       bin = BIN_EARLY;
        else if (arr_x > close_t) bin = BIN_LATE;
        else                      bin = BIN_ONTIME;
    end
endmodule

// File: rtl/awc_counter_bank.sv
module awc_counter_bank #(
    parameter int N_CNT = 100,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [N_CNT-1:0] inc,
    output logic [CNT_W-1:0] cnt [N_CNT]
);
    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst || clr)
                cnt[g] <= '0;
            else if (inc[g] && (cnt[g] != {CNT_W{1'b1}}))
                cnt[g] <= cnt[g] + 1'b1;
        end
    end
endmodule

// File: rtl/awc_read_port.sv
module awc_read_port #(
    parameter int N_CNT = 100,
    parameter int CNT_W = 64,
    parameter int RD_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [RD_AW-1:0]   rd_addr,
    input  logic [CNT_W-1:0]   cnt [N_CNT],
    output logic [CNT_W/2-1:0] rd_data
);
    localparam int HW = CNT_W / 2;

    logic [HW-1:0]    shadow;
    logic [RD_AW-2:0] idx;
    logic             in_range;

    always_comb begin
        idx      = rd_addr[RD_AW-1:1];
        in_range = (int'(idx) < N_CNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            shadow  <= '0;
        end else if (rd_en) begin
            if (!in_range) begin
                rd_data <= '0;
            end else if (!rd_addr[0]) begin
                rd_data <= cnt[idx][HW-1:0];
                shadow  <= cnt[idx][CNT_W-1:HW];
            end else begin
                rd_data <= shadow;
            end
        end
    end
endmodule

// File: rtl/arrival_window_counters.sv
module arrival_window_counters
    import awc_pkg::*;
#(
    parameter int  PORT_W = 4,
    parameter int  TS_W   = 64,
    parameter int  DLY_W  = DLY_BITS,
    parameter int  CNT_W  = 64,
    localparam int NPORT  = 2 ** PORT_W,
    localparam int N_CNT  = IDX_CTRL + 2 * NUM_BINS * NPORT,
    localparam int RD_AW  = $clog2(2 * N_CNT + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic [2:0]         cfg_addr,
    input  logic [DLY_W-1:0]   cfg_wdata,
    input  logic               msg_valid,
    input  logic               msg_ctrl,
    input  logic               msg_dl,
    input  logic [PORT_W-1:0]  msg_port,
    input  logic [TS_W-1:0]    msg_arrival,
    input  logic [TS_W-1:0]    msg_ref,
    input  logic               rd_en,
    input  logic [RD_AW-1:0]   rd_addr,
    output logic [CNT_W/2-1:0] rd_data
);
    window_t win_user, win_ul, win_dl, win_sel;
    logic    win_en_q;
    logic    clr_pulse;
    bin_e    bin;
    logic [N_CNT-1:0] inc;
    logic [CNT_W-1:0] cnt [N_CNT];
    logic [CNT_W-1:0] cnt_total;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_user <= '0;
            win_ul   <= '0;
            win_dl   <= '0;
            win_en_q <= 1'b0;
        end else if (cfg_wr) begin
            case (cfg_addr_e'(cfg_addr))
                CFG_U_MIN:  win_user.dmin <= cfg_wdata;
                CFG_U_MAX:  win_user.dmax <= cfg_wdata;
                CFG_UL_MIN: win_ul.dmin   <= cfg_wdata;
                CFG_UL_MAX: win_ul.dmax   <= cfg_wdata;
                CFG_DL_MIN: win_dl.dmin   <= cfg_wdata;
                CFG_DL_MAX: win_dl.dmax   <= cfg_wdata;
                CFG_CTRL:   win_en_q      <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

    assign clr_pulse = cfg_wr && (cfg_addr == CFG_CTRL) && cfg_wdata[1];

    always_comb begin
        if (!msg_ctrl)   win_sel = win_user;
        else if (msg_dl) win_sel = win_dl;
        else             win_sel = win_ul;
    end

    awc_classify #(.TS_W(TS_W)) u_classify (
        .arrival (msg_arrival),
        .ref_ts  (msg_ref),
        .win     (win_sel),
        .bin     (bin)
    );

    always_comb begin
        inc = '0;
        if (msg_valid) begin
            inc[IDX_TOTAL] = 1'b1;
            if (win_en_q) begin
                if (!msg_ctrl)
                    inc[IDX_USER + int'(bin)] = 1'b1;
                else
                    inc[ctrl_index(int'(msg_dl), int'(msg_port), int'(bin), NPORT)] = 1'b1;
            end
        end
    end

    awc_counter_bank #(.N_CNT(N_CNT), .CNT_W(CNT_W)) u_bank (
        .clk (clk),
        .rst (rst),
        .clr (clr_pulse),
        .inc (inc),
        .cnt (cnt)
    );

    assign cnt_total = cnt[IDX_TOTAL];

    awc_read_port #(.N_CNT(N_CNT), .CNT_W(CNT_W), .RD_AW(RD_AW)) u_read (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .cnt     (cnt),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/awc_checker.sv
module awc_checker #(
    parameter int N_CNT = 100,
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             msg_valid,
    input logic             win_en,
    input logic             clr,
    input logic [N_CNT-2:0] inc_bins,
    input logic [CNT_W-1:0] total
);
    // R4
    total_step_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !clr && total != {CNT_W{1'b1}}) |=> (total == CNT_W'($past(total) + 1'b1)));

    // R4
    total_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!msg_valid && !clr) |=> $stable(total));

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (total == '0));

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (total == {CNT_W{1'b1}} && !clr) |=> (total == {CNT_W{1'b1}}));

    // R6
    gated_bins_chk: assert property (@(posedge clk) disable iff (rst)
        !win_en |-> (inc_bins == '0));

    // R2
    single_bin_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && win_en) |-> ($countones(inc_bins) == 1));

    // R4
    no_msg_no_bin_chk: assert property (@(posedge clk) disable iff (rst)
        !msg_valid |-> (inc_bins == '0));
endmodule

bind arrival_window_counters awc_checker #(.N_CNT(N_CNT), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .msg_valid (msg_valid),
    .win_en    (win_en_q),
    .clr       (clr_pulse),
    .inc_bins  (inc[N_CNT-1:1]),
    .total     (cnt_total)
);

// File: tb/arrival_window_counters_test.sv
module arrival_window_counters_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP   = 16;
    localparam int NC   = 4 + 6 * NP;
    localparam int AW   = $clog2(2 * NC + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic msg_valid = 1'b0, msg_valid_s = 1'b0;
    logic msg_ctrl = 1'b0, msg_dl = 1'b0;
    logic [3:0] msg_port = '0;
    logic [63:0] msg_arrival = '0, msg_ref = '0;
    logic rd_en = 1'b0, rd_en_s = 1'b0;
    logic [AW-1:0] rd_addr = '0, rd_addr_s = '0;
    logic [31:0] rd_data;
    logic [3:0]  rd_data_s;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    longint unsigned exp_cnt [NC];
    longint unsigned bmin [3];
    longint unsigned bmax [3];
    bit en_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    arrival_window_counters uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .msg_valid(msg_valid), .msg_ctrl(msg_ctrl), .msg_dl(msg_dl), .msg_port(msg_port),
        .msg_arrival(msg_arrival), .msg_ref(msg_ref),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    arrival_window_counters #(.CNT_W(8)) uut_sat (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .msg_valid(msg_valid_s), .msg_ctrl(msg_ctrl), .msg_dl(msg_dl), .msg_port(msg_port),
        .msg_arrival(msg_arrival), .msg_ref(msg_ref),
        .rd_en(rd_en_s), .rd_addr(rd_addr_s), .rd_data(rd_data_s)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung, expected completion");
        finish_run();
    end

    task automatic check(input string req, input longint unsigned act, input longint unsigned expv);
        vectors++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // R2: bin 0 early, 1 on time, 2 late; inclusive edges, early test first
    function automatic int classify(input longint unsigned arr, input longint unsigned rf,
                                    input longint unsigned mn, input longint unsigned mx);
        logic [64:0] a, o, c;
        a = {1'b0, arr};
        o = {1'b0, rf} + {1'b0, mn};
        c = {1'b0, rf} + {1'b0, mx};
        if (a < o) return 0;
        if (a > c) return 2;
        return 1;
    endfunction

    task automatic cfg_write(input int addr, input longint unsigned data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 32'(data);
        @(negedge clk);
        cfg_wr = 1'b0;
        if (addr < 6) begin
            if (addr % 2 == 0) bmin[addr/2] = data; else bmax[addr/2] = data;
        end else begin
            en_m = data[0];
            if (data[1]) for (int k = 0; k < NC; k++) exp_cnt[k] = 0;
        end
    endtask

    task automatic model_msg(input bit c, input bit d, input int p,
                             input longint unsigned arr, input longint unsigned rf);
        int sel, b;
        exp_cnt[0]++;
        if (en_m) begin
            sel = !c ? 0 : (d ? 2 : 1);
            b = classify(arr, rf, bmin[sel], bmax[sel]);
            if (!c) exp_cnt[1 + b]++;
            else    exp_cnt[4 + 3 * (int'(d) * NP + p) + b]++;
        end
    endtask

    task automatic send(input bit c, input bit d, input int p,
                        input longint unsigned arr, input longint unsigned rf);
        @(negedge clk);
        msg_valid = 1'b1; msg_ctrl = c; msg_dl = d; msg_port = 4'(p);
        msg_arrival = arr; msg_ref = rf;
        @(negedge clk);
        msg_valid = 1'b0;
        model_msg(c, d, p, arr, rf);
    endtask

    task automatic rd_word(input int addr, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(addr);
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic rd_small(input int addr, output logic [3:0] v);
        @(negedge clk);
        rd_en_s = 1'b1; rd_addr_s = AW'(addr);
        @(negedge clk);
        rd_en_s = 1'b0;
        v = rd_data_s;
    endtask

    task automatic pulse_small(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            msg_valid_s = 1'b1;
        end
        @(negedge clk);
        msg_valid_s = 1'b0;
    endtask

    // R7: words 2k/2k+1 of counter k
    task automatic sweep(input string req);
        logic [31:0] lo, hi;
        for (int k = 0; k < NC; k++) begin
            rd_word(2 * k, lo);
            rd_word(2 * k + 1, hi);
            check(req, {hi, lo}, exp_cnt[k]);
        end
    endtask

    initial begin
        logic [31:0] w;
        logic [3:0]  s;
        longint unsigned rf, arr;
        for (int k = 0; k < NC; k++) exp_cnt[k] = 0;
        for (int k = 0; k < 3; k++) begin bmin[k] = 0; bmax[k] = 0; end
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        sweep("R1 reset");

        // R6 enable low: only total moves
        cfg_write(0, 500);  cfg_write(1, 1500);
        cfg_write(2, 800);  cfg_write(3, 2000);
        cfg_write(4, 200);  cfg_write(5, 900);
        send(0, 0, 0, 100, 5000);
        send(1, 0, 3, 5900, 5000);
        send(1, 1, 9, 9000, 5000);
        sweep("R6 gating");

        // R2 R3 R5 directed window edges
        cfg_write(6, 1);
        rf = 64'd1_000_000;
        send(0, 1, 7, rf + 500, rf);  send(0, 0, 2, rf + 499, rf);
        send(0, 0, 0, rf + 1500, rf); send(0, 1, 5, rf + 1501, rf);
        send(1, 0, 3, rf + 800, rf);  send(1, 0, 3, rf + 799, rf);
        send(1, 0, 3, rf + 2000, rf); send(1, 0, 3, rf + 2001, rf);
        send(1, 1, 15, rf + 200, rf); send(1, 1, 15, rf + 199, rf);
        send(1, 1, 15, rf + 900, rf); send(1, 1, 15, rf + 901, rf);
        send(1, 1, 0, 64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FF00);
        sweep("R2 R3 R5 edges");

        // R2 R5 inverted bounds: early test first
        cfg_write(2, 3000); cfg_write(3, 1000);
        send(1, 0, 1, rf + 2000, rf);
        send(1, 0, 1, rf + 3500, rf);
        cfg_write(2, 800);  cfg_write(3, 2000);
        sweep("R2 inverted");

        // R3 R4 R5 random traffic
        for (int i = 0; i < 400; i++) begin
            rf  = longint'($urandom) << 4;
            arr = rf + longint'($urandom_range(0, 3000));
            send(1'($urandom), 1'($urandom), int'($urandom_range(0, 15)), arr, rf);
        end
        sweep("R3 R4 R5 random");

        // R8 control write without clear bit
        cfg_write(6, 1);
        sweep("R8 no clear");

        // R8 clear in the same cycle as a message
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 3'd6; cfg_wdata = 32'd3;
        msg_valid = 1'b1; msg_ctrl = 1'b0; msg_arrival = 64'd600; msg_ref = 64'd0;
        @(negedge clk);
        cfg_wr = 1'b0; msg_valid = 1'b0;
        for (int k = 0; k < NC; k++) exp_cnt[k] = 0;
        sweep("R8 clear wins");

        // R7 out of range word reads zero
        send(0, 0, 0, 600, 0);
        rd_word(2 * NC, w);
        check("R7 out of range", w, 0);

        // R10 shadow on the 8-bit instance
        pulse_small(15);
        rd_small(0, s);  check("R10 low", s, 15);
        pulse_small(1);
        rd_small(1, s);  check("R10 shadow high", s, 0);
        rd_small(0, s);  check("R10 low again", s, 0);
        rd_small(1, s);  check("R10 high again", s, 1);

        // R9 saturation
        pulse_small(250);
        rd_small(0, s);  check("R9 low sat", s, 15);
        rd_small(1, s);  check("R9 high sat", s, 15);

        finish_run();
    end
endmodule